// File: doc/BRIEF.md
# Cascaded Two-Channel Time Base

This block builds a wide free-running time base out of two narrow counter channels instead of one wide register. The lower channel counts ticks of a selectable divided clock and drives a waveform output that goes high as the count wraps to zero and low again at mid-range. The upper channel has no clock of its own. It counts rising edges of that waveform after passing it through a two-stage synchronizer and an edge detector, so it advances once for each full turn of the lower channel.

A single-cycle sync pulse clears both channels, the prescaler and the synchronizer together, which restarts the whole time base from zero. Both channel counts are visible on ports. A read sequencer returns a combined value with the upper count in the high half and the lower count in the low half. It samples the upper half, then the lower half, waits until any wrap of the lower half has had time to reach the upper channel, and samples the upper half again. If the two upper samples differ it starts over, so a torn value is never returned. The lower divisor is meant to be chosen so that the count rate is at least 5 MHz.

Top module: `cascade_timer32`

## Requirements
- R1: While reset is held, and in the cycle after a sync pulse is sampled, both counts are zero, the waveform output is low and the read sequencer is idle.
- R2: The lower count advances by one every D clock cycles, where D = 2^(div_sel_i × DIV_SHIFT). A div_sel_i value above NUM_DIV-1 is treated as NUM_DIV-1. So k cycles after a sync or reset, the lower count is floor(k/D) mod 2^CNT_W.
- R3: The waveform output goes high in the same cycle that the lower count wraps from all ones to zero. It goes low in the cycle that the lower count reaches 2^(CNT_W-1). It stays low after a sync or reset until the first wrap.
- R4: The upper count advances by exactly one for each rising edge of the waveform output, SYNC_STAGES+1 cycles after that edge. The zero that the lower count holds right after a sync is not a wrap and is not counted.
- R5: The upper count wraps modulo 2^CNT_W, from all ones back to zero.
- R6: A start request accepted while idle raises busy. The read later ends with a one-cycle done pulse, and busy is low in that cycle. The returned value is {upper, lower} with the upper count in bits [2·CNT_W-1:CNT_W]. It equals the true lower-tick count since sync, modulo 2^(2·CNT_W), at some cycle between the start and the done, and is never torn across a wrap.
- R7: A start request that arrives while a read is in progress is ignored. It neither restarts nor extends the read, and no second done pulse follows.
- R8: A sync pulse during a read aborts it. Busy is low in the next cycle and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Single-cycle pulse that clears both channels together |
| div_sel_i | input | SEL_W | Selects the lower-channel divisor 2^(sel × DIV_SHIFT) |
| rd_start_i | input | 1 | Requests a consistent combined read |
| lo_count_o | output | CNT_W | Lower channel count |
| hi_count_o | output | CNT_W | Upper channel count |
| lo_wave_o | output | 1 | Lower channel waveform; its rising edges clock the upper channel |
| rd_busy_o | output | 1 | A read is in progress |
| rd_done_o | output | 1 | One-cycle pulse when rd_value_o holds a new result |
| rd_value_o | output | 2*CNT_W | Combined value {upper, lower} from the last completed read |

## Verification
The bench builds the block with CNT_W = 6, NUM_DIV = 4 and DIV_SHIFT = 1, which gives divisors of 1, 2, 4 and 8. A lower wrap then takes 64 to 512 cycles, so every divisor produces many upper increments in a short run. At divisor 1 the upper count also wraps after about 4100 cycles, which brings R5 within reach. Reads are started at random gaps and also at fixed offsets around each lower wrap, so the retry path is exercised on purpose.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
   typedef enum logic [1:0] {
      RS_IDLE   = 2'd0,
      RS_LOWER  = 2'd1,
      RS_SETTLE = 2'd2
   } rd_state_e;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
   parameter int NUM_DIV   = 4,
   parameter int DIV_SHIFT = 2,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic [SEL_W-1:0] div_sel_i,
   output logic             tick_o
);
   generate
      if (NUM_DIV == 1) begin : g_direct
         logic unused_in;
         assign unused_in = ^{clk, rst_n, sync_i, div_sel_i};
         assign tick_o = 1'b1;
      end else begin : g_divided
         localparam int PRE_W = (NUM_DIV - 1) * DIV_SHIFT + 1;
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] lim;
         int               sel_c;

         always_comb begin
            if (int'(div_sel_i) >= NUM_DIV) sel_c = NUM_DIV - 1;
            else                            sel_c = int'(div_sel_i);
            lim = (PRE_W'(1) << (sel_c * DIV_SHIFT)) - PRE_W'(1);
         end

         // >= keeps the counter bounded if the divisor shrinks mid-run
         assign tick_o = (pre_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (sync_i || tick_o) pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end

         // R2: after a sync the prescaler restarts from zero
         a_r2_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sync_i) |-> pre_q == '0);
      end
   endgenerate
endmodule

// File: rtl/ct_lo_chan.sv
module ct_lo_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wave_o
);
   localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] HALF_V = CNT_W'(1) << (CNT_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         wave_o <= 1'b0;
      end else if (sync_i) begin
         cnt_o  <= '0;
         wave_o <= 1'b0;
      end else if (tick_i) begin
         cnt_o <= cnt_o + 1'b1;
         if (cnt_o == TOP_V)                wave_o <= 1'b1;
         else if (cnt_o == HALF_V - 1'b1)   wave_o <= 1'b0;
      end
   end

   // R2: the lower count only ever steps by one outside a sync
   a_r2_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sync_i) && cnt_o != $past(cnt_o)) |-> cnt_o == $past(cnt_o) + 1'b1);

   // R3: waveform rises exactly as the count lands on zero
   a_r3_wave_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wave_o) |-> cnt_o == '0);

   // R3: waveform falls at mid-range unless a sync cleared it
   a_r3_wave_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wave_o) && !$past(sync_i)) |-> cnt_o == HALF_V);
endmodule

// File: rtl/ct_hi_chan.sv
module ct_hi_chan #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             wave_i,
   output logic [CNT_W-1:0] cnt_o
);
   // SYNC_STAGES synchronizer flops plus one history flop for the edge
   logic [SYNC_STAGES:0] shift_q;
   logic                 edge_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shift_q <= '0;
      else if (sync_i) shift_q <= '0;
      else             shift_q <= {shift_q[SYNC_STAGES-1:0], wave_i};
   end

   assign edge_w = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (sync_i) cnt_o <= '0;
      else if (edge_w) cnt_o <= cnt_o + 1'b1;
   end

   // R4 / R5: the upper count steps by one (modulo) outside a sync
   a_r4_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sync_i) && cnt_o != $past(cnt_o)) |-> cnt_o == $past(cnt_o) + 1'b1);

   // R4: no two increments on back-to-back cycles
   a_r4_hi_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sync_i) && cnt_o != $past(cnt_o)) |=> $stable(cnt_o) || $past(sync_i));
endmodule

// File: rtl/ct_read_seq.sv
module ct_read_seq
   import cascade_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int LAT   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   input  logic               start_i,
   input  logic [CNT_W-1:0]   lo_i,
   input  logic [CNT_W-1:0]   hi_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [2*CNT_W-1:0] value_o
);
   localparam int WC_W = (LAT > 1) ? $clog2(LAT + 1) : 1;

   rd_state_e        st_q;
   logic [CNT_W-1:0] up_q;
   logic [CNT_W-1:0] lo_q;
   logic [WC_W-1:0]  wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RS_IDLE;
         up_q    <= '0;
         lo_q    <= '0;
         wait_q  <= '0;
         done_o  <= 1'b0;
         value_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (sync_i) begin
            st_q <= RS_IDLE;
         end else begin
            case (st_q)
               RS_IDLE: if (start_i) begin
                  up_q <= hi_i;
                  st_q <= RS_LOWER;
               end
               RS_LOWER: begin
                  lo_q   <= lo_i;
                  wait_q <= '0;
                  st_q   <= RS_SETTLE;
               end
               RS_SETTLE: begin
                  // wait until a wrap seen in lo_q has reached the upper channel
                  if (wait_q == WC_W'(LAT - 1)) begin
                     if (hi_i == up_q) begin
                        value_o <= {up_q, lo_q};
                        done_o  <= 1'b1;
                        st_q    <= RS_IDLE;
                     end else begin
                        up_q <= hi_i;
                        st_q <= RS_LOWER;
                     end
                  end else begin
                     wait_q <= wait_q + 1'b1;
                  end
               end
               default: st_q <= RS_IDLE;
            endcase
         end
      end
   end

   assign busy_o = (st_q != RS_IDLE);

   // R6: a done pulse only follows a cycle of activity, and lasts one cycle
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o) && !busy_o);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: sync aborts any read without a result
   a_r8_sync_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_i) |-> !busy_o && !done_o);
endmodule

// File: rtl/cascade_timer32.sv
module cascade_timer32 #(
   parameter int  CNT_W       = 16,
   parameter int  NUM_DIV     = 4,
   parameter int  DIV_SHIFT   = 2,
   parameter int  SYNC_STAGES = 2,
   localparam int SEL_W       = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   input  logic [SEL_W-1:0]   div_sel_i,
   input  logic               rd_start_i,
   output logic [CNT_W-1:0]   lo_count_o,
   output logic [CNT_W-1:0]   hi_count_o,
   output logic               lo_wave_o,
   output logic               rd_busy_o,
   output logic               rd_done_o,
   output logic [2*CNT_W-1:0] rd_value_o
);
   // cycles from a waveform rise to the upper-count update
   localparam int HI_LAT = SYNC_STAGES + 1;

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("cascade_timer32: CNT_W must be at least 4");
      end
      if (NUM_DIV < 1) begin : g_bad_ndiv
         $error("cascade_timer32: NUM_DIV must be at least 1");
      end
      if (DIV_SHIFT < 1) begin : g_bad_shift
         $error("cascade_timer32: DIV_SHIFT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cascade_timer32: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic tick_w;

   ct_prescaler #(
      .NUM_DIV  (NUM_DIV),
      .DIV_SHIFT(DIV_SHIFT),
      .SEL_W    (SEL_W)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_i),
      .div_sel_i(div_sel_i),
      .tick_o   (tick_w)
   );

   ct_lo_chan #(
      .CNT_W(CNT_W)
   ) u_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .sync_i(sync_i),
      .tick_i(tick_w),
      .cnt_o (lo_count_o),
      .wave_o(lo_wave_o)
   );

   ct_hi_chan #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .sync_i(sync_i),
      .wave_i(lo_wave_o),
      .cnt_o (hi_count_o)
   );

   ct_read_seq #(
      .CNT_W(CNT_W),
      .LAT  (HI_LAT)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_i),
      .start_i(rd_start_i),
      .lo_i   (lo_count_o),
      .hi_i   (hi_count_o),
      .busy_o (rd_busy_o),
      .done_o (rd_done_o),
      .value_o(rd_value_o)
   );

   // R1: one cycle after a sync the whole time base is back at zero
   a_r1_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sync_i) |-> lo_count_o == '0 && hi_count_o == '0 && !lo_wave_o);
endmodule

// File: tb/cascade_timer32_tb_top.sv
module cascade_timer32_tb_top;
   localparam int W   = 6;
   localparam int ND  = 4;
   localparam int DS  = 1;
   localparam int SS  = 2;
   localparam int LAT = SS + 1;
   localparam int CW  = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync = 1'b0;
   logic          rd_start = 1'b0;
   logic [1:0]    div_sel = 2'd0;
   logic [W-1:0]  lo_c, hi_c;
   logic          wave, rd_busy, rd_done;
   logic [CW-1:0] rd_value;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   bit  mon_en = 1'b0;

   longint unsigned k = 0;
   int unsigned     d_q = 1;

   always #4 clk = ~clk;

   cascade_timer32 #(
      .CNT_W(W), .NUM_DIV(ND), .DIV_SHIFT(DS), .SYNC_STAGES(SS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sync_i(sync), .div_sel_i(div_sel),
      .rd_start_i(rd_start), .lo_count_o(lo_c), .hi_count_o(hi_c),
      .lo_wave_o(wave), .rd_busy_o(rd_busy), .rd_done_o(rd_done),
      .rd_value_o(rd_value)
   );

   function automatic int unsigned f_div(int s);
      return 32'd1 << (s * DS);
   endfunction

   function automatic longint unsigned exp_lo(longint unsigned kk, int unsigned dd);
      return (kk / dd) % (64'd1 << W);
   endfunction

   function automatic longint unsigned exp_hi(longint unsigned kk, int unsigned dd);
      if (kk < LAT) return 0;
      return ((kk - LAT) / dd / (64'd1 << W)) % (64'd1 << W);
   endfunction

   function automatic bit exp_wave(longint unsigned kk, int unsigned dd);
      return ((kk / dd) >= (64'd1 << W)) && (exp_lo(kk, dd) < (64'd1 << (W - 1)));
   endfunction

   // cycle count since the last sync or reset, and the divisor in force
   always @(posedge clk) begin
      if (!rst_n || sync) begin
         k   <= 0;
         d_q <= f_div(int'(div_sel));
      end else begin
         k <= k + 1;
      end
   end

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // continuous model comparison, sampled away from the edge
   always @(posedge clk) begin
      #2;
      if (mon_en && !finished) begin
         chk(longint'(lo_c) == longint'(exp_lo(k, d_q)), "R2 lower count", lo_c, exp_lo(k, d_q));
         chk(longint'(hi_c) == longint'(exp_hi(k, d_q)), "R4 R5 upper count", hi_c, exp_hi(k, d_q));
         chk(wave == exp_wave(k, d_q), "R3 waveform", wave, exp_wave(k, d_q));
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic sync_pulse(int sel);
      div_sel = 2'(sel);
      sync = 1'b1;
      cyc();
      sync = 1'b0;
      chk(lo_c == '0 && hi_c == '0 && !wave && !rd_busy, "R1 after sync",
          {lo_c, hi_c, wave, rd_busy}, 0);
   endtask

   task automatic do_read();
      longint unsigned kp;
      logic [CW-1:0]   lb, ub, v;
      int              n;
      kp = k;
      lb = CW'((kp + 1) / d_q);
      rd_start = 1'b1;
      cyc();
      rd_start = 1'b0;
      chk(rd_busy, "R6 busy after start", rd_busy, 1);
      n = 0;
      while (!rd_done && n < 100) begin
         cyc();
         n++;
      end
      if (!rd_done) begin
         chk(1'b0, "R6 read completion", 0, 1);
      end else begin
         v  = rd_value;
         ub = CW'(k / d_q);
         chk((v - lb) <= (ub - lb), "R6 consistent value", v, lb);
         chk(!rd_busy, "R6 busy released at done", rd_busy, 0);
      end
   endtask

   task automatic reads_near_wrap();
      longint unsigned per;
      longint unsigned tgt;
      per = longint'(d_q) << W;
      for (int off = -3; off <= 3; off++) begin
         tgt = (per + longint'(off)) % per;
         while (((k + 1) % per) != tgt) cyc();
         do_read();
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int n_done;
      void'($urandom(32'h1357));
      repeat (3) cyc();
      // R1: reset state
      chk(lo_c == '0 && hi_c == '0 && !wave && !rd_busy && !rd_done, "R1 reset state",
          {lo_c, hi_c, wave, rd_busy, rd_done}, 0);
      rst_n = 1'b1;
      mon_en = 1'b1;

      for (int sel = 0; sel < ND; sel++) begin
         sync_pulse(sel);
         while (k < ((sel == 0) ? 64'd3800 : 64'd3000)) begin
            repeat ($urandom_range(0, 40)) cyc();
            do_read();
         end
         if (sel == 0) begin
            // R5: upper count wraps from all ones to zero
            while (k != 64'd4098) cyc();
            chk(hi_c == 6'd63, "R5 upper at top", hi_c, 63);
            cyc();
            chk(hi_c == 6'd0, "R5 upper wrapped", hi_c, 0);
         end
         reads_near_wrap();
         if (sel == 1) begin
            // R1: sync while the waveform is high
            while (!wave) cyc();
            sync_pulse(1);
            repeat (200) cyc();
         end
      end

      // R7: a second start during a read is ignored
      cyc();
      rd_start = 1'b1;
      cyc();
      rd_start = 1'b0;
      n_done = 0;
      for (int i = 0; i < 30; i++) begin
         if (i == 1) rd_start = 1'b1;
         if (i == 2) rd_start = 1'b0;
         if (rd_done) n_done++;
         cyc();
      end
      chk(n_done == 1, "R7 single done", n_done, 1);
      chk(!rd_busy, "R7 idle after read", rd_busy, 0);

      // R8: sync during a read aborts it
      rd_start = 1'b1;
      cyc();
      rd_start = 1'b0;
      cyc();
      chk(rd_busy, "R8 read in progress", rd_busy, 1);
      sync = 1'b1;
      cyc();
      sync = 1'b0;
      chk(!rd_busy, "R8 busy dropped", rd_busy, 0);
      n_done = 0;
      for (int i = 0; i < 15; i++) begin
         if (rd_done) n_done++;
         cyc();
      end
      chk(n_done == 0, "R8 no done", n_done, 0);

      summary();
   end
endmodule